// File: doc/BRIEF.md
# Serial Link Adapter Host Register Block

This block sits between an 8-bit host I/O bus and a byte-wide serial link engine. The host sees a small register window at a configurable base address. Through it the host reads bytes that the link engine delivered, hands bytes to the engine for sending, polls or enables interrupts for both directions, and controls an attached processor's reset and analyse lines. The same window also lets the host sample that processor's error line. The engine side uses plain valid/ready byte ports, and the serial bit protocol is outside this block.

Each direction has a one-byte holding register with a flag. The receive flag is set when the engine delivers a byte and cleared when the host reads the data offset. The send flag is set by a host write and cleared when the engine takes the byte. A single interrupt line combines the two flags with their enables. A software reset bit clears the data path and both enables for as long as it is held. The error input passes through a synchroniser before the host can read it.

Top module: `lnk_host_regs`

## Requirements
- R1: After the synchronous reset input, a read of offset 0x02 returns 0x00, a read of offset 0x03 returns 0x01, and irq_o, proc_reset_o and proc_analyse_o are 0.
- R2: A byte taken from the engine (rx_valid_i and rx_ready_o both high at a clock edge) is returned by a read of offset 0x00, and bit 0 of offset 0x02 reads 1 while it waits. rx_ready_o is low while a byte waits and no read of 0x00 is in progress. A read of 0x00 clears the waiting bit. Bits 7:1 of every status read are 0.
- R3: When a read of offset 0x00 and a new engine byte fall in the same cycle, the read returns the old byte, the new byte is captured, and the waiting bit stays 1.
- R4: A write to offset 0x01 while output status bit 0 is 1 presents the byte on tx_data_o with tx_valid_o high, and output status bit 0 reads 0 until the engine takes the byte (tx_valid_o and tx_ready_i both high at an edge). A write to 0x01 while the previous byte is still pending is dropped.
- R5: Bit 0 of a write to offset 0x02 or 0x03 sets or clears the input or output interrupt enable. irq_o is (input enable AND byte waiting) OR (output enable AND output ready).
- R6: Bit 0 of a write to offset 0x10 drives proc_reset_o. From the next cycle, and for as long as it stays 1, both holding registers, both flags and both enables are cleared, rx_ready_o and tx_valid_o are low, writes to 0x01 to 0x03 are ignored, input status reads 0 and output status reads 1.
- R7: A read of offset 0x10 returns in bit 0 the value proc_error_i had SYNC_STAGES clock edges earlier (two by default).
- R8: Bit 0 of a write to offset 0x11 drives proc_analyse_o, and a read of 0x11 returns it in bit 0.
- R9: The window is the 32 bytes whose upper address bits match BASE_ADDR (0x40 to 0x5F by default). Addresses outside it, unmapped offsets inside it, and reads of the write-only offset 0x01 return 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid while bus_rd is high |
| rx_valid_i | input | 1 | Engine offers a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Block can take a received byte |
| tx_valid_o | output | 1 | Byte waiting to be sent |
| tx_data_o | output | 8 | Byte to send |
| tx_ready_i | input | 1 | Engine takes the byte |
| proc_reset_o | output | 1 | Reset to attached processor and adapter |
| proc_analyse_o | output | 1 | Analyse control to attached processor |
| proc_error_i | input | 1 | Error line from attached processor (asynchronous) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The interesting overlap is a host read of the input data offset in the same cycle that the engine offers the next byte. The read opens rx_ready_o, so the byte is taken on that edge. The bench sets this up on purpose with a full holding register and rx_valid_i held high during the read. It then checks that the read returned the old byte, that the flag stayed set, and that the next read returns the new byte. A soft-reset write meeting engine traffic or enable writes is a second overlap. A long pseudo-random phase provokes it, and a behavioural model checks every output on every cycle.

// File: rtl/lnk_host_pkg.sv
package lnk_host_pkg;

    localparam int BYTE_W = 8;
    localparam int WIN_W  = 5;

    localparam logic [WIN_W-1:0] OFF_RXDATA  = 5'h00;
    localparam logic [WIN_W-1:0] OFF_TXDATA  = 5'h01;
    localparam logic [WIN_W-1:0] OFF_INSTAT  = 5'h02;
    localparam logic [WIN_W-1:0] OFF_OUTSTAT = 5'h03;
    localparam logic [WIN_W-1:0] OFF_RESET   = 5'h10;
    localparam logic [WIN_W-1:0] OFF_ANALYSE = 5'h11;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RXDATA,
        SEL_TXDATA,
        SEL_INSTAT,
        SEL_OUTSTAT,
        SEL_RESET,
        SEL_ANALYSE
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_sel_e          sel;
        logic [BYTE_W-1:0] wdata;
    } bus_op_t;

    function automatic reg_sel_e decode_offset(input logic [WIN_W-1:0] off);
        reg_sel_e s;
        case (off)
            OFF_RXDATA:  s = SEL_RXDATA;
            OFF_TXDATA:  s = SEL_TXDATA;
            OFF_INSTAT:  s = SEL_INSTAT;
            OFF_OUTSTAT: s = SEL_OUTSTAT;
            OFF_RESET:   s = SEL_RESET;
            OFF_ANALYSE: s = SEL_ANALYSE;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] flag_byte(input logic b);
        return {{(BYTE_W-1){1'b0}}, b};
    endfunction

endpackage

// File: rtl/lnk_host_decode.sv
module lnk_host_decode
    import lnk_host_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h40
) (
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output bus_op_t           op,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] BASE_VEC = ADDR_W'(BASE_ADDR);

    always_comb begin
        hit      = (bus_addr[ADDR_W-1:WIN_W] == BASE_VEC[ADDR_W-1:WIN_W]);
        op.rd    = bus_rd && hit;
        op.wr    = bus_wr && hit;
        op.sel   = hit ? decode_offset(bus_addr[WIN_W-1:0]) : SEL_NONE;
        op.wdata = bus_wdata;
    end
endmodule

// File: rtl/lnk_host_rxbuf.sv
module lnk_host_rxbuf
    import lnk_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              srst,
    input  logic              consume,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              full,
    output logic [BYTE_W-1:0] data
);
    logic load;

    always_comb begin
        rx_ready = !srst && (!full || consume);
        load     = rx_valid && rx_ready;
    end

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            full <= 1'b0;
            data <= '0;
        end else if (load) begin
            full <= 1'b1;
            data <= rx_data;
        end else if (consume) begin
            full <= 1'b0;
        end
    end

    a_r2_data_held: assert property (@(posedge clk) disable iff (rst)
        (full && !load && !srst) |=> $stable(data));
    a_r2_read_empties: assert property (@(posedge clk) disable iff (rst)
        (consume && !load) |=> !full);
    a_r3_refill_keeps_flag: assert property (@(posedge clk) disable iff (rst)
        (load && consume) |=> full);
endmodule

// File: rtl/lnk_host_txbuf.sv
module lnk_host_txbuf
    import lnk_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              srst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              full
);
    logic take;

    always_comb begin
        tx_valid = full && !srst;
        take     = tx_valid && tx_ready;
    end

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            full    <= 1'b0;
            tx_data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full    <= 1'b1;
            tx_data <= wr_data;
        end
    end

    a_r4_hold_until_taken: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> $stable(tx_data));
    a_r4_busy_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> $stable(tx_data));
endmodule

// File: rtl/lnk_host_ctrl.sv
module lnk_host_ctrl
    import lnk_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  reg_sel_e sel,
    input  logic     wbit,
    input  logic     err_in,
    output logic     srst,
    output logic     analyse,
    output logic     in_en,
    output logic     out_en,
    output logic     err_sync
);
    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            srst    <= 1'b0;
            analyse <= 1'b0;
        end else if (wr) begin
            if (sel == SEL_RESET)   srst    <= wbit;
            if (sel == SEL_ANALYSE) analyse <= wbit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            in_en  <= 1'b0;
            out_en <= 1'b0;
        end else if (wr) begin
            if (sel == SEL_INSTAT)  in_en  <= wbit;
            if (sel == SEL_OUTSTAT) out_en <= wbit;
        end
    end

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else     sync_q[i] <= err_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else     sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign err_sync = sync_q[SYNC_STAGES-1];

    a_r6_enables_cleared: assert property (@(posedge clk) disable iff (rst)
        srst |=> (!in_en && !out_en));
    a_r8_analyse_follows_write: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_ANALYSE) |=> (analyse == $past(wbit)));
endmodule

// File: rtl/lnk_host_regs.sv
module lnk_host_regs
    import lnk_host_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int BASE_ADDR   = 'h40,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_data_i,
    output logic              rx_ready_o,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    input  logic              tx_ready_i,
    output logic              proc_reset_o,
    output logic              proc_analyse_o,
    input  logic              proc_error_i,
    output logic              irq_o
);
    bus_op_t           op;
    logic              hit;
    logic              srst, in_en, out_en, err_sync;
    logic              rx_full, tx_full;
    logic [BYTE_W-1:0] rx_byte;
    logic              consume, tx_wr;

    lnk_host_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .op(op), .hit(hit)
    );

    always_comb begin
        consume = op.rd && (op.sel == SEL_RXDATA);
        tx_wr   = op.wr && (op.sel == SEL_TXDATA);
    end

    lnk_host_rxbuf u_rx (
        .clk(clk), .rst(rst), .srst(srst), .consume(consume),
        .rx_valid(rx_valid_i), .rx_data(rx_data_i), .rx_ready(rx_ready_o),
        .full(rx_full), .data(rx_byte)
    );

    lnk_host_txbuf u_tx (
        .clk(clk), .rst(rst), .srst(srst), .wr_en(tx_wr), .wr_data(op.wdata),
        .tx_ready(tx_ready_i), .tx_valid(tx_valid_o), .tx_data(tx_data_o),
        .full(tx_full)
    );

    lnk_host_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .clk(clk), .rst(rst), .wr(op.wr), .sel(op.sel), .wbit(op.wdata[0]),
        .err_in(proc_error_i), .srst(srst), .analyse(proc_analyse_o),
        .in_en(in_en), .out_en(out_en), .err_sync(err_sync)
    );

    always_comb begin
        bus_rdata = '0;
        if (op.rd) begin
            case (op.sel)
                SEL_RXDATA:  bus_rdata = rx_byte;
                SEL_INSTAT:  bus_rdata = flag_byte(rx_full);
                SEL_OUTSTAT: bus_rdata = flag_byte(!tx_full);
                SEL_RESET:   bus_rdata = flag_byte(err_sync);
                SEL_ANALYSE: bus_rdata = flag_byte(proc_analyse_o);
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign proc_reset_o = srst;
    assign irq_o        = (in_en && rx_full) || (out_en && !tx_full);

    a_r9_outside_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !hit) |-> (bus_rdata == '0));
    a_r6_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
        (proc_reset_o && $past(proc_reset_o)) |-> (!irq_o && !tx_valid_o && !rx_ready_o));
    a_r2_status_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && hit && bus_addr[WIN_W-1:0] == OFF_INSTAT) |-> (bus_rdata[7:1] == '0));
endmodule

// File: tb/lnk_host_regs_test.sv
module lnk_host_regs_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready, tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;
    logic       proc_reset, proc_analyse, irq;
    logic       proc_error = 1'b0;

    lnk_host_regs uut (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
        .proc_reset_o(proc_reset), .proc_analyse_o(proc_analyse),
        .proc_error_i(proc_error), .irq_o(irq)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic       m_rxf = 0, m_txf = 0, m_ien = 0, m_oen = 0, m_srst = 0, m_an = 0;
    logic       m_e1 = 0, m_e2 = 0;
    logic [7:0] m_rxd = 0, m_txd = 0;

    function automatic logic in_win();
        return bus_addr[7:5] == 3'd2;
    endfunction

    function automatic logic [7:0] exp_rdata();
        if (!(bus_rd && in_win())) return 8'h00;
        case (bus_addr[4:0])
            5'h00:   return m_rxd;
            5'h02:   return {7'b0, m_rxf};
            5'h03:   return {7'b0, !m_txf};
            5'h10:   return {7'b0, m_e2};
            5'h11:   return {7'b0, m_an};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_rx_ready();
        return !m_srst && (!m_rxf || (bus_rd && in_win() && bus_addr[4:0] == 5'h00));
    endfunction

    always @(posedge clk) begin : model
        logic w, rd0, rdy;
        logic [4:0] off;
        if (rst) begin
            m_rxf = 0; m_txf = 0; m_ien = 0; m_oen = 0; m_srst = 0; m_an = 0;
            m_e1 = 0; m_e2 = 0; m_rxd = 0; m_txd = 0;
        end else begin
            off = bus_addr[4:0];
            w   = bus_wr && in_win();
            rd0 = bus_rd && in_win() && off == 5'h00;
            rdy = exp_rx_ready();
            if (m_srst) begin
                m_rxf = 0; m_rxd = 0; m_txf = 0; m_txd = 0; m_ien = 0; m_oen = 0;
            end else begin
                if (rx_valid && rdy) begin m_rxd = rx_data; m_rxf = 1; end
                else if (rd0) m_rxf = 0;
                if (m_txf && tx_ready) m_txf = 0;
                else if (w && off == 5'h01 && !m_txf) begin m_txf = 1; m_txd = bus_wdata; end
                if (w && off == 5'h02) m_ien = bus_wdata[0];
                if (w && off == 5'h03) m_oen = bus_wdata[0];
            end
            m_e2 = m_e1;
            m_e1 = proc_error;
            if (w && off == 5'h10) m_srst = bus_wdata[0];
            if (w && off == 5'h11) m_an = bus_wdata[0];
        end
    end

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("bus_rdata", bus_rdata, exp_rdata());
        chk("rx_ready", {7'b0, rx_ready}, {7'b0, exp_rx_ready()});
        chk("tx_valid", {7'b0, tx_valid}, {7'b0, m_txf && !m_srst});
        if (m_txf && !m_srst) chk("tx_data", tx_data, m_txd);
        chk("proc_reset", {7'b0, proc_reset}, {7'b0, m_srst});
        chk("proc_analyse", {7'b0, proc_analyse}, {7'b0, m_an});
        chk("irq", {7'b0, irq}, {7'b0, (m_ien && m_rxf) || (m_oen && !m_txf)});
    endtask

    task automatic bus(input logic rd, input logic wr, input logic [7:0] a, input logic [7:0] d);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1;
        if (!rst) cmp_all();
        @(negedge clk);
    endtask

    task automatic idle();
        bus(1'b0, 1'b0, 8'h00, 8'h00);
    endtask

    task automatic rdx(input logic [7:0] a, input logic [7:0] exp);
        bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = 8'h00;
        #1;
        cmp_all();
        chk($sformatf("read %h", a), bus_rdata, exp);
        @(negedge clk);
    endtask

    task automatic pin(input string what, input logic act, input logic exp);
        #1;
        chk(what, {7'b0, act}, {7'b0, exp});
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        idle();
        rx_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        cur_req = "R1";
        pin("irq after reset", irq, 1'b0);
        pin("proc_reset after reset", proc_reset, 1'b0);
        pin("analyse after reset", proc_analyse, 1'b0);
        rdx(8'h42, 8'h00);
        rdx(8'h43, 8'h01);

        cur_req = "R2";
        push(8'hA5);
        pin("rx_ready while full", rx_ready, 1'b0);
        rx_valid = 1'b1; rx_data = 8'h99;   // offered while full, must wait
        idle();
        rdx(8'h42, 8'h01);
        rdx(8'h40, 8'hA5);
        rx_valid = 1'b0;
        rdx(8'h42, 8'h01);                  // waiting 0x99 taken after the read
        rdx(8'h40, 8'h99);
        rdx(8'h42, 8'h00);

        cur_req = "R3";
        push(8'h11);
        rx_valid = 1'b1; rx_data = 8'h22;
        rdx(8'h40, 8'h11);
        rx_valid = 1'b0;
        rdx(8'h42, 8'h01);
        rdx(8'h40, 8'h22);
        rdx(8'h42, 8'h00);

        cur_req = "R4";
        tx_ready = 1'b0;
        bus(1'b0, 1'b1, 8'h41, 8'h5C);
        pin("tx_valid after write", tx_valid, 1'b1);
        chk("tx_data after write", tx_data, 8'h5C);
        rdx(8'h43, 8'h00);
        bus(1'b0, 1'b1, 8'h41, 8'h77);
        chk("tx_data after busy write", tx_data, 8'h5C);
        rdx(8'h41, 8'h00);
        tx_ready = 1'b1;
        idle();
        tx_ready = 1'b0;
        rdx(8'h43, 8'h01);
        pin("tx_valid after take", tx_valid, 1'b0);

        cur_req = "R5";
        bus(1'b0, 1'b1, 8'h43, 8'h01);
        pin("irq output ready", irq, 1'b1);
        bus(1'b0, 1'b1, 8'h43, 8'h00);
        pin("irq output disabled", irq, 1'b0);
        bus(1'b0, 1'b1, 8'h42, 8'h01);
        pin("irq input empty", irq, 1'b0);
        push(8'h3C);
        pin("irq input waiting", irq, 1'b1);
        rdx(8'h40, 8'h3C);
        pin("irq input consumed", irq, 1'b0);

        cur_req = "R6";
        push(8'h44);
        bus(1'b0, 1'b1, 8'h41, 8'h66);
        bus(1'b0, 1'b1, 8'h50, 8'h01);
        idle();
        pin("proc_reset asserted", proc_reset, 1'b1);
        pin("rx_ready in reset", rx_ready, 1'b0);
        pin("tx_valid in reset", tx_valid, 1'b0);
        pin("irq in reset", irq, 1'b0);
        rdx(8'h42, 8'h00);
        rdx(8'h43, 8'h01);
        bus(1'b0, 1'b1, 8'h41, 8'h12);
        bus(1'b0, 1'b1, 8'h43, 8'h01);
        bus(1'b0, 1'b1, 8'h50, 8'h00);
        idle();
        pin("proc_reset released", proc_reset, 1'b0);
        pin("tx_valid after ignored write", tx_valid, 1'b0);
        pin("irq enable ignored", irq, 1'b0);
        rdx(8'h40, 8'h00);

        cur_req = "R7";
        proc_error = 1'b1;
        rdx(8'h50, 8'h00);
        idle();
        rdx(8'h50, 8'h01);
        proc_error = 1'b0;
        idle(); idle();
        rdx(8'h50, 8'h00);

        cur_req = "R8";
        bus(1'b0, 1'b1, 8'h51, 8'h01);
        pin("analyse set", proc_analyse, 1'b1);
        rdx(8'h51, 8'h01);
        bus(1'b0, 1'b1, 8'h51, 8'hFE);
        pin("analyse cleared", proc_analyse, 1'b0);

        cur_req = "R9";
        push(8'h81);
        rdx(8'h60, 8'h00);
        rdx(8'h20, 8'h00);
        rdx(8'h45, 8'h00);
        bus(1'b0, 1'b1, 8'h62, 8'h01);
        pin("irq after outside enable write", irq, 1'b0);
        bus(1'b0, 1'b1, 8'h61, 8'h33);
        pin("tx_valid after outside write", tx_valid, 1'b0);
        bus(1'b0, 1'b1, 8'h4F, 8'h01);
        rdx(8'h4F, 8'h00);
        rdx(8'h40, 8'h81);

        cur_req = "R3";   // mixed traffic: reads, refills, soft reset overlaps
        for (int i = 0; i < 600; i++) begin
            logic [7:0] addrs [8] = '{8'h40, 8'h41, 8'h42, 8'h43, 8'h50, 8'h51, 8'h45, 8'h61};
            int k;
            k = $urandom_range(0, 7);
            rx_valid   = ($urandom_range(0, 1) == 1);
            rx_data    = 8'($urandom);
            tx_ready   = ($urandom_range(0, 2) == 0);
            proc_error = ($urandom_range(0, 3) == 0);
            case ($urandom_range(0, 2))
                0: idle();
                1: bus(1'b1, 1'b0, addrs[k], 8'h00);
                default: bus(1'b0, 1'b1, addrs[k],
                             (addrs[k] == 8'h50) ? {7'b0, ($urandom_range(0, 3) == 0)} : 8'($urandom));
            endcase
        end
        finish_run();
    end
endmodule